// File: doc/BRIEF.md
# Trace Buffer Identification Register Read Unit

This unit answers reads of a 64-bit identification word that tells software how the trace buffer may be used. The processor has four privilege levels (EL0 to EL3) and two security states. On each read request the unit takes the reader's level and security state, which optional levels exist, and the ownership controls set by the two highest levels. From these it builds the word. The word holds a fixed flag-update capability bit, a fixed minimum-alignment code and a "programming not allowed" bit that is computed per read.

The same unit decides the fate of the read. It either returns the word, reports the access as undefined, or reports a trap to EL2 with a 6-bit exception class. The answer is registered and appears one clock after the request strobe. The trace buffer itself, address translation and exception entry belong to other blocks.

Top module: `trbid_reader`

## Requirements
- R1: `rsp_valid` is 1 in the cycle after a cycle in which `rd_req` is sampled high, and 0 after a cycle in which it is sampled low. The response fields change only when a request is taken.
- R2: A read that returns data carries zeros in bits 63:6, `FLAG_UPD` in bit 5, the programming-not-allowed bit in bit 4 and `ALIGN_CODE` in bits 3:0. `ALIGN_CODE` c means a minimum alignment of 2^c bytes. Values above 11 are rejected at elaboration.
- R3: With EL3 present and `el3_own` equal to 00 or 01 (secure owner), bit 4 is 1 for a reader at non-secure EL1, for a reader at non-secure EL2, and for a reader at secure EL1 when secure EL2 is implemented and enabled and `el2_ctl` is 00.
- R4: With EL3 present and `el3_own` equal to 10 or 11 (non-secure owner), bit 4 is 1 for a reader at secure EL1, for a reader at secure EL2 when secure EL2 is implemented, and for a reader at non-secure EL1 when EL2 is present and `el2_ctl` is 00.
- R5: With EL3 absent, EL2 present and `el2_ctl` equal to 00, bit 4 is 1 for a reader at EL1.
- R6: In every case not covered by R3 to R5, bit 4 is 0. This includes every read at EL3.
- R7: A read at EL0 gives `rsp_undef`=1, `rsp_trap`=0 and data 0.
- R8: A read at EL1 traps when three conditions all hold: `el2_on`=1, either EL3 is absent or `fgt_en`=1, and `rd_trap`=1. A trap gives `rsp_trap`=1, `rsp_tgt`=2, `rsp_ec`=0x18 and data 0. Any other EL1 read returns the word.
- R9: Reads at EL2 and EL3 never set `rsp_undef` or `rsp_trap`.
- R10: While reset is held, and after it, until the first request is taken, `rsp_valid`, `rsp_undef` and `rsp_trap` are 0 and `rsp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request strobe |
| cur_lvl | input | 2 | Reader privilege level, 0 to 3 |
| cur_ns | input | 1 | Reader is in the non-secure state |
| has_el3 | input | 1 | EL3 is implemented |
| has_el2 | input | 1 | EL2 is implemented |
| sec_el2_impl | input | 1 | Secure EL2 is implemented |
| sec_el2_en | input | 1 | Secure EL2 is enabled |
| el3_own | input | 2 | EL3 ownership control; the upper bit selects the non-secure owner |
| el2_ctl | input | 2 | EL2 trace-buffer control |
| el2_on | input | 1 | EL2 is enabled for the reader's security state |
| fgt_en | input | 1 | EL3 fine-grained-trap enable |
| rd_trap | input | 1 | EL2 read-trap bit for this register |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Register value, or 0 on a fault |
| rsp_undef | output | 1 | Access is undefined |
| rsp_trap | output | 1 | Access traps |
| rsp_tgt | output | 2 | Trap target level |
| rsp_ec | output | 6 | Trap exception class |

## Verification
Some rules are checked by assertions on every cycle: the one-cycle request-to-response timing, undefined and trap never both set, zero data on any fault, zero reserved bits, the exception class and target on a trap, and the absence of faults for EL2 and EL3 readers. The value of the programming-not-allowed bit depends on the full set of ownership, level and implementation inputs. Only the bench's scenarios can show it is right: a table of hand-worked cases and an exhaustive sweep compared with a model built from the rules. The same holds for which EL1 combinations trap.

// File: rtl/trbid_reader.sv
module trbid_reader #(
  parameter logic       FLAG_UPD   = 1'b1,
  parameter logic [3:0] ALIGN_CODE = 4'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [1:0]  cur_lvl,
  input  logic        cur_ns,
  input  logic        has_el3,
  input  logic        has_el2,
  input  logic        sec_el2_impl,
  input  logic        sec_el2_en,
  input  logic [1:0]  el3_own,
  input  logic [1:0]  el2_ctl,
  input  logic        el2_on,
  input  logic        fgt_en,
  input  logic        rd_trap,
  output logic        rsp_valid,
  output logic [63:0] rsp_data,
  output logic        rsp_undef,
  output logic        rsp_trap,
  output logic [1:0]  rsp_tgt,
  output logic [5:0]  rsp_ec
);

  localparam logic [5:0] TRAP_EC  = 6'h18;
  localparam logic [1:0] TRAP_LVL = 2'd2;
  localparam int         MAX_ALIGN = 11;

  if (ALIGN_CODE > MAX_ALIGN) begin : g_bad_align
    $error("ALIGN_CODE must be 11 or less");
  end

  logic at_el1, at_el2, ctl_zero, no_prog;
  logic is_undef, is_trap;
  logic [63:0] word;

  assign at_el1   = (cur_lvl == 2'd1);
  assign at_el2   = (cur_lvl == 2'd2);
  assign ctl_zero = (el2_ctl == 2'b00);

  always_comb begin
    if (has_el3) begin
      if (!el3_own[1])
        no_prog = cur_ns ? (at_el1 || at_el2)
                         : (at_el1 && sec_el2_impl && sec_el2_en && ctl_zero);
      else
        no_prog = cur_ns ? (at_el1 && has_el2 && ctl_zero)
                         : (at_el1 || (at_el2 && sec_el2_impl));
    end else begin
      no_prog = at_el1 && has_el2 && ctl_zero;
    end
  end

  assign is_undef = (cur_lvl == 2'd0);
  assign is_trap  = at_el1 && el2_on && (!has_el3 || fgt_en) && rd_trap;
  assign word     = {58'd0, FLAG_UPD, no_prog, ALIGN_CODE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_undef <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_tgt   <= '0;
      rsp_ec    <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        rsp_undef <= is_undef;
        rsp_trap  <= is_trap;
        rsp_data  <= (is_undef || is_trap) ? 64'd0 : word;
        rsp_tgt   <= is_trap ? TRAP_LVL : 2'd0;
        rsp_ec    <= is_trap ? TRAP_EC : 6'd0;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_data[63:6] == 58'd0); // R2
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cur_lvl == 2'd0) |=> (rsp_undef && !rsp_trap)); // R7
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_undef && rsp_trap)); // R7
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_undef || rsp_trap) |-> (rsp_data == 64'd0)); // R8
  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_ec == 6'h18 && rsp_tgt == 2'd2)); // R8
  AST_HIGH_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cur_lvl[1]) |=> (!rsp_undef && !rsp_trap)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!rsp_valid && !rsp_undef && !rsp_trap)); // R10

endmodule

// File: tb/tb_trbid_reader.sv
`timescale 1ns/1ps
module tb_trbid_reader;
  localparam logic       FLAG = 1'b1;
  localparam logic [3:0] ALN  = 4'd4;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst_n;
  logic rd_req;
  logic [1:0] cur_lvl;
  logic cur_ns, has_el3, has_el2, sec_el2_impl, sec_el2_en;
  logic [1:0] el3_own, el2_ctl;
  logic el2_on, fgt_en, rd_trap;
  logic rsp_valid, rsp_undef, rsp_trap;
  logic [63:0] rsp_data;
  logic [1:0] rsp_tgt;
  logic [5:0] rsp_ec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trbid_reader #(.FLAG_UPD(FLAG), .ALIGN_CODE(ALN)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cur_lvl(cur_lvl), .cur_ns(cur_ns),
    .has_el3(has_el3), .has_el2(has_el2), .sec_el2_impl(sec_el2_impl),
    .sec_el2_en(sec_el2_en), .el3_own(el3_own), .el2_ctl(el2_ctl), .el2_on(el2_on),
    .fgt_en(fgt_en), .rd_trap(rd_trap), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_tgt(rsp_tgt), .rsp_ec(rsp_ec));

  // {lvl[2], ns, el3, el2, simp, sen, own[2], ctl[2], on, fgt, tb, exp_p, exp_undef, exp_trap}
  localparam logic [16:0] VEC [NVEC] = '{
    17'b01_1_1_1_0_0_00_00_0_0_0_1_0_0, // R3 ns EL1
    17'b10_1_1_1_0_0_01_00_0_0_0_1_0_0, // R3 ns EL2
    17'b01_0_1_1_1_1_00_00_0_0_0_1_0_0, // R3 s EL1 ctl 00
    17'b01_0_1_1_1_1_00_01_0_0_0_0_0_0, // R6 s EL1 ctl 01
    17'b01_0_1_1_1_0_00_00_0_0_0_0_0_0, // R6 s EL2 disabled
    17'b01_0_1_1_0_0_10_11_0_0_0_1_0_0, // R4 s EL1
    17'b10_0_1_1_1_0_11_00_0_0_0_1_0_0, // R4 s EL2 impl
    17'b10_0_1_1_0_0_11_00_0_0_0_0_0_0, // R6 s EL2 not impl
    17'b01_1_1_1_0_0_10_00_0_0_0_1_0_0, // R4 ns EL1 ctl 00
    17'b01_1_1_1_0_0_10_10_0_0_0_0_0_0, // R6 ns EL1 ctl 10
    17'b10_1_1_1_0_0_10_00_0_0_0_0_0_0, // R6 ns EL2 ns owner
    17'b01_1_0_1_0_0_00_00_0_0_0_1_0_0, // R5 no EL3 EL1
    17'b10_1_0_1_0_0_00_00_0_0_0_0_0_0, // R6 no EL3 EL2
    17'b11_0_1_1_0_0_00_00_0_0_0_0_0_0, // R6 EL3 reader
    17'b00_1_1_1_0_0_00_00_1_1_1_0_1_0, // R7 EL0
    17'b01_1_1_1_0_0_10_01_1_1_1_0_0_1, // R8 trap fgt on
    17'b01_1_1_1_0_0_10_01_1_0_1_0_0_0, // R8 fgt off
    17'b01_1_0_1_0_0_00_01_1_0_1_0_0_1, // R8 no EL3 trap
    17'b10_1_1_1_0_0_10_01_1_1_1_0_0_0  // R9 EL2 trap bits set
  };

  function automatic logic ref_p(logic [1:0] l, logic ns, logic e3, logic e2,
                                 logic si, logic se, logic [1:0] ow, logic [1:0] ct);
    logic one, two, cz;
    one = (l == 2'd1); two = (l == 2'd2); cz = (ct == 2'b00);
    if (e3 && ow[1] == 1'b0)
      return ns ? (one || two) : (one && si && se && cz);
    if (e3)
      return ns ? (one && e2 && cz) : (one || (two && si));
    return one && e2 && cz;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, logic [16:0] v, logic ep, logic eu, logic et);
    logic [63:0] ed;
    @(negedge clk);
    {cur_lvl, cur_ns, has_el3, has_el2, sec_el2_impl, sec_el2_en,
     el3_own, el2_ctl, el2_on, fgt_en, rd_trap} = v[16:3];
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    ed = (eu || et) ? 64'd0 : {58'd0, FLAG, ep, ALN};
    check(req, {rsp_valid, rsp_undef, rsp_trap}, {1'b1, eu, et});
    check(req, rsp_data, ed);
    check(req, {rsp_tgt, rsp_ec}, et ? {2'd2, 6'h18} : 8'd0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_req = 1'b1;
    {cur_lvl, cur_ns, has_el3, has_el2, sec_el2_impl, sec_el2_en,
     el3_own, el2_ctl, el2_on, fgt_en, rd_trap} = '0;
    repeat (3) @(negedge clk);
    check("R10 reset flags", {rsp_valid, rsp_undef, rsp_trap}, 3'b000);
    check("R10 reset data", rsp_data, 64'd0);
    rd_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {rsp_valid, rsp_data}, 65'd0);

    for (int i = 0; i < NVEC; i++)
      read_chk("R2/R3/R4/R5/R6/R7/R8/R9 table", VEC[i], VEC[i][2], VEC[i][1], VEC[i][0]);

    @(negedge clk);
    check("R1 valid drops without request", rsp_valid, 1'b0);
    read_chk("R1 hold base", 17'b01_1_1_1_0_0_00_00_0_0_0_1_0_0, 1'b1, 1'b0, 1'b0);
    cur_lvl = 2'd0;
    @(negedge clk);
    check("R1 fields held while idle", {rsp_undef, rsp_data}, {1'b0, 58'd0, FLAG, 1'b1, ALN});

    @(negedge clk);
    {cur_lvl, cur_ns, has_el3, has_el2, sec_el2_impl, sec_el2_en,
     el3_own, el2_ctl, el2_on, fgt_en, rd_trap} = 14'b00_1_1_1_0_0_00_00_0_0_0;
    rd_req = 1'b1;
    @(negedge clk);
    check("R7 back-to-back first", {rsp_valid, rsp_undef}, 2'b11);
    cur_lvl = 2'd3;
    @(negedge clk);
    rd_req = 1'b0;
    check("R9 back-to-back second", {rsp_valid, rsp_undef, rsp_trap}, 3'b100);
    check("R2 back-to-back data", rsp_data, {58'd0, FLAG, 1'b0, ALN});

    for (int k = 0; k < 16384; k++) begin
      logic [13:0] s;
      logic eu, et, ep;
      s = k[13:0];
      eu = (s[13:12] == 2'd0);
      et = (s[13:12] == 2'd1) && s[2] && (!s[10] || s[1]) && s[0];
      ep = ref_p(s[13:12], s[11], s[10], s[9], s[8], s[7], s[6:5], s[4:3]);
      read_chk("R3/R4/R5/R6/R7/R8/R9 sweep", {s, 3'b000}, ep, eu, et);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule